// File: doc/BRIEF.md
# Funnel Shifter with Condition Flags

This execution unit joins two 32-bit source words into one 64-bit value, with the high word in bits 63:32 and the low word in bits 31:0. It shifts that value left or right and returns a single 32-bit word. A right shift returns the bottom 32 bits of the shifted value. A left shift returns the top 32 bits. Writing the same word into both sources gives a 32-bit rotate. By chaining several operations, software can build shifts and rotates wider than 64 bits.

The shift amount comes from a 32-bit register operand or from a 6-bit immediate. It is then either clamped to a limit or masked to that limit's range, where the limit is 32 or 64. For right shifts, the fill above the value is zeros (logical) or copies of bit 63 (arithmetic). A high option adds 32 to the amount after clamping or masking.

A four-bit flag register holds zero, carry, sign and overflow. An operation can update all four flags. It can also accumulate only the zero flag, so that a multi-word sequence ends with flags that describe the whole wide result. The unit flags illegal option combinations. One result, with its flags, appears in the cycle after each accepted operation.

Top module: `funnel_shift_unit`

## Requirements
- R1: For a right shift (`op_left`=0), `res_data` is the low 32 bits of {`src_hi`,`src_lo`} shifted right by the effective amount. The fill is zeros when `op_width` is 0 (limit 32) or 1 (limit 64, logical). The fill is copies of `src_hi[31]` when `op_width` is 2 (limit 64, arithmetic).
- R2: For a left shift (`op_left`=1), `res_data` is bits 63:32 of {`src_hi`,`src_lo`} shifted left by the effective amount, with zeros entering from below.
- R3: With `op_wrap`=0, the raw amount is treated as unsigned and limited to the range 0 to M. M is 32 for `op_width` 0 and 64 for `op_width` 1 or 2.
- R4: With `op_wrap`=1, the raw amount is ANDed with M-1.
- R5: When `op_ext` is 2 or 3, 32 is added to the amount after clamping or masking. A right shift by 64 or more returns pure fill.
- R6: With `op_imm_sel`=1, the raw amount is `op_imm` zero-extended. Otherwise it is `op_amt`.
- R7: `res_valid` is high in exactly the cycle after each cycle with `op_valid`=1. `res_data`, `res_err` and the updated `flags_o` are presented in that same cycle.
- R8: With `op_cc`=1 and `op_ext` 0 or 2, all four flags are written. The flag bits are `flags_o`[0]=zero (result==0), [1]=carry, [2]=sign (result bit 31) and [3]=overflow (always written 0). Carry is the last bit shifted out past the returned window, or 0 when the effective amount is 0.
- R9: With `op_ext`=1, the new zero flag is the old zero flag AND (result==0). Carry, sign and overflow keep their values.
- R10: With `op_ext`=3, zero accumulates as in R9, carry keeps its value, sign is result bit 31 and overflow is written 0.
- R11: An operation with `op_cc`=0 leaves `flags_o` unchanged.
- R12: Some combinations are illegal: `op_width`=2 with a left shift, `op_ext` 2 or 3 with a left shift, `op_ext` 1 or 3 without `op_cc`, and `op_width`=3. Any of these sets `res_err`, returns a zero result and leaves the flags unchanged.
- R13: Equal source words with a right shift by n give the 32-bit word rotated right by n.
- R14: After reset, `res_valid` is 0, `res_data` is 0 and `flags_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_left | input | 1 | 1 = left shift, 0 = right shift |
| op_wrap | input | 1 | 1 = mask amount, 0 = clamp amount |
| op_width | input | 2 | 0 = limit 32, 1 = limit 64 logical, 2 = limit 64 arithmetic, 3 = reserved |
| op_ext | input | 2 | 0 = plain, 1 = accumulate zero, 2 = high offset, 3 = high offset with accumulate |
| op_cc | input | 1 | Write condition flags |
| op_imm_sel | input | 1 | Take amount from immediate |
| op_imm | input | 6 | Immediate shift amount |
| op_amt | input | 32 | Register shift amount |
| src_hi | input | 32 | Upper source word (bits 63:32) |
| src_lo | input | 32 | Lower source word (bits 31:0) |
| res_valid | output | 1 | Result present |
| res_data | output | 32 | Result word |
| res_err | output | 1 | Illegal option combination |
| flags_o | output | 4 | {overflow, sign, carry, zero} |

## Verification
The assertions check the following on every cycle:
- the effective amount stays within its bounds;
- no carry is produced at a zero amount;
- overflow never rises;
- the flags stay frozen across illegal operations and operations with `op_cc`=0;
- the accumulate modes never raise the zero flag and keep carry;
- each result is valid exactly one cycle after its operation.

Only the bench's scenarios can show that the returned bit window is correct for a given source, direction, fill and amount. The same holds for the clamp and mask arithmetic, the choice between immediate and register amount, rotates, and the flag values carried along a chain of operations.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [1:0] {
    FSU_W32  = 2'd0,
    FSU_U64  = 2'd1,
    FSU_S64  = 2'd2,
    FSU_WRSV = 2'd3
  } fsu_width_e;

  typedef enum logic [1:0] {
    FSU_PLAIN = 2'd0,
    FSU_ACC   = 2'd1,
    FSU_HI    = 2'd2,
    FSU_ACCHI = 2'd3
  } fsu_ext_e;

  typedef struct packed {
    logic ov;
    logic sg;
    logic cy;
    logic zr;
  } fsu_flags_t;
endpackage

// File: rtl/fsu_amount.sv
module fsu_amount #(
  parameter int W  = 32,
  parameter int SW = 7
) (
  input  logic [W-1:0]  raw,
  input  logic          wrap,
  input  logic          wide,
  input  logic          hi,
  output logic [SW-1:0] amt,
  output logic          saturated
);
  logic [W:0] lim_w;

  function automatic logic [SW-1:0] base_amount(input logic [W-1:0] r,
                                                input logic wr,
                                                input logic [W:0] lim);
    logic [W:0] rr;
    rr = {1'b0, r};
    if (wr) return SW'(rr & (lim - 1'b1));
    else if (rr > lim) return SW'(lim);
    else return SW'(rr);
  endfunction

  assign lim_w     = wide ? (W+1)'(2*W) : (W+1)'(W);
  assign saturated = !wrap && ({1'b0, raw} > lim_w);
  assign amt       = base_amount(raw, wrap, lim_w) + (hi ? SW'(W) : SW'(0));
endmodule

// File: rtl/fsu_datapath.sv
module fsu_datapath #(
  parameter int W  = 32,
  parameter int SW = 7
) (
  input  logic [W-1:0]  hi_w,
  input  logic [W-1:0]  lo_w,
  input  logic          left,
  input  logic          arith,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  res,
  output logic          carry
);
  localparam int EW = 4 * W;

  function automatic logic [W:0] funnel(input logic [W-1:0] h,
                                        input logic [W-1:0] l,
                                        input logic lf,
                                        input logic ar,
                                        input logic [SW-1:0] s);
    logic [EW-1:0] ext;
    logic [EW-1:0] sh;
    logic [EW-1:0] pre;
    logic          cy;
    if (lf) begin
      ext = {{(2*W){1'b0}}, h, l};
      sh  = ext << s;
      cy  = (s != '0) && sh[2*W];
      return {cy, sh[2*W-1:W]};
    end else begin
      ext = {{(2*W){ar & h[W-1]}}, h, l};
      sh  = ext >> s;
      pre = ext >> (s - 1'b1);
      cy  = (s != '0) && pre[0];
      return {cy, sh[W-1:0]};
    end
  endfunction

  assign {carry, res} = funnel(hi_w, lo_w, left, arith, amt);
endmodule

// File: rtl/fsu_flags.sv
module fsu_flags
  import fsu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic [1:0]  mode,
  input  logic [W-1:0] res,
  input  logic        carry,
  output fsu_flags_t  flags_q
);
  fsu_flags_t nxt;
  logic       res_zero;

  assign res_zero = (res == '0);

  always_comb begin
    nxt = flags_q;
    if (upd) begin
      case (fsu_ext_e'(mode))
        FSU_ACC: nxt.zr = flags_q.zr & res_zero;
        FSU_ACCHI: begin
          nxt.zr = flags_q.zr & res_zero;
          nxt.sg = res[W-1];
          nxt.ov = 1'b0;
        end
        default: begin
          nxt.zr = res_zero;
          nxt.cy = carry;
          nxt.sg = res[W-1];
          nxt.ov = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt;
  end

  assert_acc_keeps_csv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == FSU_ACC) |=> ($stable(flags_q.cy) && $stable(flags_q.sg) && $stable(flags_q.ov)));

  assert_acc_zero_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode[0] && !flags_q.zr) |=> !flags_q.zr);

  assert_xhi_keeps_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode == FSU_ACCHI) |=> $stable(flags_q.cy));

  assert_idle_holds_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));

  assert_ov_never_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q.ov);
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import fsu_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_left,
  input  logic            op_wrap,
  input  logic [1:0]      op_width,
  input  logic [1:0]      op_ext,
  input  logic            op_cc,
  input  logic            op_imm_sel,
  input  logic [IMMW-1:0] op_imm,
  input  logic [W-1:0]    op_amt,
  input  logic [W-1:0]    src_hi,
  input  logic [W-1:0]    src_lo,
  output logic            res_valid,
  output logic [W-1:0]    res_data,
  output logic            res_err,
  output logic [3:0]      flags_o
);
  localparam int SW = $clog2(3*W + 1);

  function automatic logic illegal_combo(input logic lf, input logic [1:0] wd,
                                         input logic [1:0] ex, input logic cc);
    return (lf && wd == FSU_S64) || (lf && ex[1]) ||
           (ex[0] && !cc) || (wd == FSU_WRSV);
  endfunction

  logic [W-1:0]  raw_amt;
  logic [SW-1:0] eff_amt;
  logic          amt_sat;
  logic [W-1:0]  dp_res;
  logic          dp_carry;
  logic          op_err;
  logic          flag_upd;
  fsu_flags_t    flags_q;

  assign raw_amt  = op_imm_sel ? W'(op_imm) : op_amt;
  assign op_err   = illegal_combo(op_left, op_width, op_ext, op_cc);
  assign flag_upd = op_valid && op_cc && !op_err;

  fsu_amount #(.W(W), .SW(SW)) amount_i (
    .raw       (raw_amt),
    .wrap      (op_wrap),
    .wide      (op_width != FSU_W32),
    .hi        (op_ext[1]),
    .amt       (eff_amt),
    .saturated (amt_sat)
  );

  fsu_datapath #(.W(W), .SW(SW)) datapath_i (
    .hi_w  (src_hi),
    .lo_w  (src_lo),
    .left  (op_left),
    .arith (op_width == FSU_S64),
    .amt   (eff_amt),
    .res   (dp_res),
    .carry (dp_carry)
  );

  fsu_flags #(.W(W)) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (flag_upd),
    .mode    (op_ext),
    .res     (dp_res),
    .carry   (dp_carry),
    .flags_q (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_data <= op_err ? '0 : dp_res;
        res_err  <= op_err;
      end
    end
  end

  assign flags_o = flags_q;

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);

  assert_err_keeps_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_err) |=> $stable(flags_o));

  assert_no_cc_keeps_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_cc) |=> $stable(flags_o));

  assert_zero_amt_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_amt == '0) |-> !dp_carry);

  assert_amt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eff_amt <= SW'(3*W));

  assert_wrap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wrap && !op_ext[1] && op_width == FSU_W32) |-> (eff_amt < SW'(W)));

  assert_clamp_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (amt_sat && !op_ext[1]) |-> (eff_amt == ((op_width == FSU_W32) ? SW'(W) : SW'(2*W))));
endmodule

// File: tb/funnel_shift_unit_tb_top.sv
`timescale 1ns/1ps
module funnel_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_left = 1'b0;
  logic        op_wrap = 1'b0;
  logic [1:0]  op_width = 2'd0;
  logic [1:0]  op_ext = 2'd0;
  logic        op_cc = 1'b0;
  logic        op_imm_sel = 1'b0;
  logic [5:0]  op_imm = 6'd0;
  logic [31:0] op_amt = 32'd0;
  logic [31:0] src_hi = 32'd0;
  logic [31:0] src_lo = 32'd0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_err;
  logic [3:0]  flags_o;

  int   vec_cnt = 0;
  int   miss_cnt = 0;
  bit   done = 1'b0;
  logic [3:0]  mfl = 4'd0;
  logic [36:0] q_val[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  funnel_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_left(op_left),
    .op_wrap(op_wrap), .op_width(op_width), .op_ext(op_ext), .op_cc(op_cc),
    .op_imm_sel(op_imm_sel), .op_imm(op_imm), .op_amt(op_amt),
    .src_hi(src_hi), .src_lo(src_lo), .res_valid(res_valid),
    .res_data(res_data), .res_err(res_err), .flags_o(flags_o)
  );

  // Reference: bit-by-bit selection of the 32-bit window
  function automatic logic [32:0] ref_shift(logic [31:0] h, logic [31:0] l,
                                            bit lf, bit ar, int s);
    logic [63:0] v;
    logic [31:0] r;
    logic        fill;
    logic        cy;
    v = {h, l};
    fill = ar & h[31];
    for (int i = 0; i < 32; i++) begin
      int idx;
      idx = lf ? (32 + i - s) : (i + s);
      if (lf) r[i] = (idx >= 0) ? v[idx] : 1'b0;
      else    r[i] = (idx < 64) ? v[idx] : fill;
    end
    if (s == 0) cy = 1'b0;
    else if (lf) cy = (64 - s >= 0) ? v[64 - s] : 1'b0;
    else cy = (s - 1 < 64) ? v[s - 1] : fill;
    return {cy, r};
  endfunction

  function automatic int ref_amount(longint raw, bit wr, logic [1:0] wd, bit hi);
    longint m;
    longint s;
    m = (wd == 2'd0) ? 32 : 64;
    s = wr ? (raw & (m - 1)) : ((raw > m) ? m : raw);
    if (hi) s = s + 32;
    return int'(s);
  endfunction

  task automatic issue(bit lf, bit wr, logic [1:0] wd, logic [1:0] ex, bit cc,
                       bit isel, logic [5:0] imm, logic [31:0] amt,
                       logic [31:0] h, logic [31:0] l, string tag);
    bit          err;
    logic [32:0] o;
    logic [31:0] er;
    longint      raw;
    int          s;
    err = (lf && wd == 2'd2) || (lf && ex[1]) || (ex[0] && !cc) || (wd == 2'd3);
    raw = isel ? longint'(imm) : longint'({32'd0, amt});
    s = ref_amount(raw, wr, wd, ex[1]);
    o = ref_shift(h, l, lf, wd == 2'd2, s);
    er = err ? 32'd0 : o[31:0];
    if (!err && cc) begin
      case (ex)
        2'd1: mfl[0] = mfl[0] & (er == 0);
        2'd3: begin mfl[0] = mfl[0] & (er == 0); mfl[2] = er[31]; mfl[3] = 1'b0; end
        default: mfl = {1'b0, er[31], o[32], er == 0};
      endcase
    end
    @(negedge clk);
    q_val.push_back({er, err, mfl});
    q_tag.push_back(tag);
    op_valid = 1'b1; op_left = lf; op_wrap = wr; op_width = wd; op_ext = ex;
    op_cc = cc; op_imm_sel = isel; op_imm = imm; op_amt = amt;
    src_hi = h; src_lo = l;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      op_valid = 1'b0;
      op_amt = 32'hdead_beef;
    end
  endtask

  // Monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      vec_cnt++;
      if (q_val.size() == 0) begin
        miss_cnt++;
        $display("FAIL R7: unexpected result res=%h, expected no result", res_data);
      end else begin
        logic [36:0] e;
        string t;
        e = q_val.pop_front();
        t = q_tag.pop_front();
        if ({res_data, res_err, flags_o} !== e) begin
          miss_cnt++;
          $display("FAIL %s: got res=%h err=%b flags=%b, expected res=%h err=%b flags=%b",
                   t, res_data, res_err, flags_o, e[36:5], e[4], e[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss_cnt++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vec_cnt++;
    if (res_valid !== 1'b0 || res_data !== 32'd0 || flags_o !== 4'd0) begin
      miss_cnt++;
      $display("FAIL R14: got valid=%b res=%h flags=%b, expected 0/0/0",
               res_valid, res_data, flags_o);
    end
    rst_n = 1'b1;
    idle(2);
    // lf wr wd ex cc isel imm amt hi lo
    issue(0, 0, 2'd0, 2'd0, 0, 0, 6'd0, 32'd8,   32'h12345678, 32'h9abcdef0, "R1 right logical 32");
    issue(0, 0, 2'd2, 2'd0, 0, 0, 6'd0, 32'd40,  32'h8765_4321, 32'h0f0f0f0f, "R1 right arithmetic 64");
    issue(0, 0, 2'd1, 2'd0, 0, 0, 6'd0, 32'd44,  32'h8765_4321, 32'h0f0f0f0f, "R1 right logical 64");
    issue(0, 0, 2'd1, 2'd0, 1, 0, 6'd0, 32'd200, 32'hffffffff, 32'hffffffff, "R3 clamp to 64");
    issue(0, 0, 2'd0, 2'd0, 0, 0, 6'd0, 32'd100, 32'hcafe_f00d, 32'h1111_2222, "R3 clamp to 32");
    issue(0, 1, 2'd0, 2'd0, 0, 0, 6'd0, 32'd37,  32'hcafe_f00d, 32'h1111_2222, "R4 wrap 32");
    issue(0, 1, 2'd1, 2'd0, 0, 0, 6'd0, 32'd70,  32'hcafe_f00d, 32'h1111_2222, "R4 wrap 64");
    issue(1, 0, 2'd0, 2'd0, 0, 0, 6'd0, 32'd4,   32'h1234_5678, 32'hf000_0000, "R2 left 32");
    issue(1, 0, 2'd1, 2'd0, 1, 0, 6'd0, 32'd64,  32'h1234_5678, 32'hf000_0001, "R2 left clamp 64");
    issue(1, 1, 2'd0, 2'd0, 0, 0, 6'd0, 32'd45,  32'h00ff_00ff, 32'habcd_ef01, "R2 left wrap");
    issue(0, 0, 2'd1, 2'd2, 0, 0, 6'd0, 32'd8,   32'h89ab_cdef, 32'h0, "R5 high offset logical");
    issue(0, 0, 2'd2, 2'd2, 0, 0, 6'd0, 32'd64,  32'h8000_0000, 32'h0, "R5 high offset arith fill");
    issue(0, 0, 2'd0, 2'd0, 0, 1, 6'd12, 32'd3,  32'h0, 32'h0012_3000, "R6 immediate amount");
    issue(0, 0, 2'd0, 2'd0, 0, 0, 6'd12, 32'd3,  32'h0, 32'h0012_3000, "R6 register amount");
    issue(0, 0, 2'd0, 2'd0, 0, 1, 6'd13, 32'd0,  32'h1357_9bdf, 32'h1357_9bdf, "R13 rotate right 13");
    // flag chain
    issue(0, 0, 2'd0, 2'd0, 1, 0, 6'd0, 32'd4,   32'h0, 32'h8, "R8 plain zero and carry");
    issue(0, 0, 2'd0, 2'd1, 1, 0, 6'd0, 32'd4,   32'h0, 32'h0, "R9 accumulate zero result");
    issue(0, 0, 2'd0, 2'd1, 1, 0, 6'd0, 32'd4,   32'h0, 32'h10, "R9 accumulate nonzero");
    issue(0, 0, 2'd1, 2'd3, 1, 0, 6'd0, 32'd0,   32'h8000_0000, 32'h0, "R10 xhi sign update");
    issue(0, 0, 2'd0, 2'd0, 0, 0, 6'd0, 32'd0,   32'h0, 32'h0, "R11 no flag write");
    issue(1, 0, 2'd2, 2'd0, 1, 0, 6'd0, 32'd3,   32'hffff_ffff, 32'h1, "R12 left arithmetic illegal");
    issue(1, 0, 2'd0, 2'd2, 1, 0, 6'd0, 32'd3,   32'hffff_ffff, 32'h1, "R12 left high illegal");
    issue(0, 0, 2'd0, 2'd1, 0, 0, 6'd0, 32'd3,   32'hffff_ffff, 32'h1, "R12 accumulate without cc");
    issue(0, 0, 2'd3, 2'd0, 1, 0, 6'd0, 32'd3,   32'hffff_ffff, 32'h1, "R12 reserved width");
    issue(1, 0, 2'd0, 2'd0, 1, 0, 6'd0, 32'd0,   32'h7fff_0000, 32'h1, "R8 zero amount no carry");
    idle(1);
    issue(0, 0, 2'd2, 2'd0, 1, 0, 6'd0, 32'd1,   32'hffff_ffff, 32'hffff_ffff, "R7 after idle gap");
    idle(4);
    vec_cnt++;
    if (q_val.size() != 0) begin
      miss_cnt++;
      $display("FAIL R7: %0d results missing, expected 0", q_val.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end
endmodule